// File: doc/BRIEF.md
# CAN Receive Message Queue with Mailbox Window

This block is a small queue for received CAN frames. A frame reception stage hands it one frame at a time: an identifier, its format and remote-request flags, a length code, eight data bytes and a 16-bit capture time. The queue holds four frames, and host software sees them through one fixed mailbox slot. The head frame appears at mailbox index 60 of a 64-slot mailbox space. Software reads the head frame from that slot, then writes the advance code to a pointer register to move on to the next frame.

A configuration register turns the queue on and selects what happens when a frame arrives while all four entries are full. In discard mode the new frame is dropped. In replace mode the new frame takes the place of the youngest stored frame. A lost frame raises a sticky overrun flag in either mode. Every frame that is stored sets a receive interrupt status bit. That bit is gated by an enable bit before it reaches the interrupt request line.

Top module: `can_rxfifo_window`

## Requirements
- R1: After reset the configuration register (address 0) reads 0x80, the interrupt status register (address 2) and the error register (address 4) read 0x00, `rx_irq` is low, and the window reads all zero.
- R2: While configuration bit 0 (enable) is 0, arriving frames are not stored. Clearing the enable bit empties the queue, so frames held before it are gone after the queue is enabled again.
- R3: At mailbox index 60 the window shows the oldest unread frame. The ID word has bit 31 = extended format and bit 30 = remote request. A standard 11-bit identifier sits in bits 28:18 with zeros below it, and an extended 29-bit identifier sits in bits 28:0. The length byte carries the code in bits 3:0 with zeros above. Data byte n occupies bits 8n+7:8n. The capture time appears unchanged.
- R4: Writing 0xFF to the pointer register (address 1) removes the head frame. Writing any other value there leaves the queue unchanged.
- R5: While the queue is empty the window shows the frame most recently removed, and a write of 0xFF to the pointer register has no effect. The next frame stored is the next one shown.
- R6: With configuration bit 3 = 1 (discard mode), a frame arriving while four frames are held is dropped, the held frames stay in order, and error register bit 5 (overrun) becomes 1. That bit is cleared by writing 0 to it.
- R7: With configuration bit 3 = 0 (replace mode), a frame arriving while four frames are held replaces the youngest held frame, and error register bit 5 becomes 1.
- R8: Interrupt status bit 4 becomes 1 on each stored frame and is cleared by writing 0 to bit 4 at address 2; a clear in the same cycle as a store loses. `rx_irq` is high exactly when status bit 4 and interrupt enable bit 4 (address 3) are both 1.
- R9: Any mailbox index other than 60 reads zero on all window outputs.
- R10: Configuration bit 7 reads 1 exactly when no frame is held. Bit 0 and bit 3 read back as written.
- R11: A frame arriving in the same cycle as an advance while four frames are held is stored without loss, and the overrun flag stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | One-cycle strobe: a received frame is present |
| rx_ide | input | 1 | Frame uses the 29-bit identifier format |
| rx_rtr | input | 1 | Frame is a remote request |
| rx_id | input | 29 | Identifier, standard form in bits 10:0 |
| rx_dlc | input | 4 | Length code |
| rx_data | input | 64 | Data bytes, byte 0 in bits 7:0 |
| rx_stamp | input | 16 | Capture time of the frame |
| reg_addr | input | 3 | Register select: 0 config, 1 pointer, 2 irq status, 3 irq enable, 4 error |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| mbx_sel | input | 6 | Mailbox index being read |
| mbx_id | output | 32 | Window ID word |
| mbx_dlc | output | 8 | Window length byte |
| mbx_data | output | 64 | Window data bytes |
| mbx_stamp | output | 16 | Window capture time |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
The bench fills the queue to its edge and pushes beyond it in both full-queue modes. A design that kept writing in discard mode would show a fifth frame on draining, and one that replaced the wrong slot in replace mode would show the wrong order. It advances on an empty queue and then stores a frame, so a design whose read pointer slipped would skip that frame. It also strikes a store and an advance together on a full queue, where a design that counted the queue as full would raise a false overrun. It times a status clear against a store, so a design that lets the clear win loses an interrupt. Finally, it disables and re-enables the queue with frames inside, where a design that kept its pointers would show stale frames.

// File: rtl/can_rxf_pkg.sv
package can_rxf_pkg;

    localparam int ID_W    = 29;
    localparam int DLC_W   = 4;
    localparam int NBYTES  = 8;
    localparam int STAMP_W = 16;
    localparam int STD_W   = 11;
    localparam int STD_LSB = 18;

    typedef struct packed {
        logic                  ide;
        logic                  rtr;
        logic [ID_W-1:0]       id;
        logic [DLC_W-1:0]      dlc;
        logic [NBYTES*8-1:0]   data;
        logic [STAMP_W-1:0]    stamp;
    } rx_frame_t;

    typedef enum logic [2:0] {
        RA_CFG      = 3'd0,
        RA_PTR      = 3'd1,
        RA_IRQ_STAT = 3'd2,
        RA_IRQ_EN   = 3'd3,
        RA_ERR      = 3'd4
    } reg_addr_e;

    localparam int         CFG_EN_BIT      = 0;
    localparam int         CFG_DISCARD_BIT = 3;
    localparam int         CFG_EMPTY_BIT   = 7;
    localparam int         IRQ_RX_BIT      = 4;
    localparam int         ERR_OVR_BIT     = 5;
    localparam logic [7:0] PTR_ADVANCE     = 8'hFF;

    // Build the host-visible ID word from a stored frame.
    function automatic logic [31:0] id_word(input rx_frame_t f);
        logic [ID_W-1:0] placed;
        if (f.ide)
            placed = f.id;
        else
            placed = {f.id[STD_W-1:0], {STD_LSB{1'b0}}};
        return {f.ide, f.rtr, placed};
    endfunction

endpackage

// File: rtl/rxf_store.sv
module rxf_store
    import can_rxf_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      en,
    input  logic      discard_mode,
    input  logic      push,
    input  rx_frame_t push_frame,
    input  logic      pop_req,
    output rx_frame_t head_frame,
    output rx_frame_t last_frame,
    output logic      empty,
    output logic      stored,
    output logic      lost
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    rx_frame_t         mem [DEPTH];
    logic [AW-1:0]     wr_ptr, rd_ptr;
    logic [CW-1:0]     count;
    logic              full, pop, accept, append, replace;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign pop     = en && pop_req && !empty;
    assign accept  = en && push;
    assign append  = accept && (!full || pop);
    assign replace = accept && full && !pop && !discard_mode;
    assign stored  = append || replace;
    assign lost    = accept && full && !pop;

    assign head_frame = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (append)
            mem[wr_ptr] <= push_frame;
        else if (replace)
            mem[wr_ptr - 1'b1] <= push_frame;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr     <= '0;
            rd_ptr     <= '0;
            count      <= '0;
            last_frame <= '0;
        end else if (!en) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (append)
                wr_ptr <= wr_ptr + 1'b1;
            if (pop) begin
                rd_ptr     <= rd_ptr + 1'b1;
                last_frame <= mem[rd_ptr];
            end
            case ({append, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assert_count_bound_R6: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

    assert_disable_flush_R2: assert property (@(posedge clk) disable iff (rst)
        !en |=> empty);

    assert_discard_holds_R6: assert property (@(posedge clk) disable iff (rst)
        (accept && full && !pop && discard_mode) |=> (full && $stable(wr_ptr)));

    assert_empty_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (en && empty && !push) |=> $stable(rd_ptr));

endmodule

// File: rtl/rxf_regs.sv
module rxf_regs
    import can_rxf_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] reg_addr,
    input  logic       reg_we,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       empty,
    input  logic       stored,
    input  logic       lost,
    output logic       en,
    output logic       discard_mode,
    output logic       pop_req,
    output logic       rx_irq
);
    logic isr_rx, ier_rx, err_ovr;
    logic wr_cfg, wr_stat, wr_ien, wr_err;

    assign wr_cfg  = reg_we && (reg_addr == RA_CFG);
    assign wr_stat = reg_we && (reg_addr == RA_IRQ_STAT);
    assign wr_ien  = reg_we && (reg_addr == RA_IRQ_EN);
    assign wr_err  = reg_we && (reg_addr == RA_ERR);
    assign pop_req = reg_we && (reg_addr == RA_PTR) && (reg_wdata == PTR_ADVANCE);
    assign rx_irq  = isr_rx && ier_rx;

    always_ff @(posedge clk) begin
        if (rst) begin
            en           <= 1'b0;
            discard_mode <= 1'b0;
            isr_rx       <= 1'b0;
            ier_rx       <= 1'b0;
            err_ovr      <= 1'b0;
        end else begin
            if (wr_cfg) begin
                en           <= reg_wdata[CFG_EN_BIT];
                discard_mode <= reg_wdata[CFG_DISCARD_BIT];
            end
            if (wr_ien)
                ier_rx <= reg_wdata[IRQ_RX_BIT];
            // a store in the same cycle wins over a write-zero clear
            if (stored)
                isr_rx <= 1'b1;
            else if (wr_stat && !reg_wdata[IRQ_RX_BIT])
                isr_rx <= 1'b0;
            if (lost)
                err_ovr <= 1'b1;
            else if (wr_err && !reg_wdata[ERR_OVR_BIT])
                err_ovr <= 1'b0;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_CFG: begin
                reg_rdata[CFG_EN_BIT]      = en;
                reg_rdata[CFG_DISCARD_BIT] = discard_mode;
                reg_rdata[CFG_EMPTY_BIT]   = empty;
            end
            RA_IRQ_STAT: reg_rdata[IRQ_RX_BIT]  = isr_rx;
            RA_IRQ_EN:   reg_rdata[IRQ_RX_BIT]  = ier_rx;
            RA_ERR:      reg_rdata[ERR_OVR_BIT] = err_ovr;
            default:     reg_rdata = '0;
        endcase
    end

    assert_isr_on_store_R8: assert property (@(posedge clk) disable iff (rst)
        stored |=> isr_rx);

    assert_ovr_on_loss_R6: assert property (@(posedge clk) disable iff (rst)
        lost |=> err_ovr);

endmodule

// File: rtl/rxf_window.sv
module rxf_window
    import can_rxf_pkg::*;
#(
    parameter int MBX_W     = 6,
    parameter int WIN_INDEX = 60
) (
    input  logic [MBX_W-1:0]      mbx_sel,
    input  logic                  empty,
    input  rx_frame_t             head_frame,
    input  rx_frame_t             last_frame,
    output logic [31:0]           mbx_id,
    output logic [7:0]            mbx_dlc,
    output logic [NBYTES*8-1:0]   mbx_data,
    output logic [STAMP_W-1:0]    mbx_stamp
);
    rx_frame_t shown;
    logic      hit;

    assign shown = empty ? last_frame : head_frame;
    assign hit   = (mbx_sel == MBX_W'(WIN_INDEX));

    always_comb begin
        if (hit) begin
            mbx_id    = id_word(shown);
            mbx_dlc   = {{(8-DLC_W){1'b0}}, shown.dlc};
            mbx_data  = shown.data;
            mbx_stamp = shown.stamp;
        end else begin
            mbx_id    = '0;
            mbx_dlc   = '0;
            mbx_data  = '0;
            mbx_stamp = '0;
        end
    end

endmodule

// File: rtl/can_rxfifo_window.sv
module can_rxfifo_window
    import can_rxf_pkg::*;
#(
    parameter int DEPTH     = 4,
    parameter int WIN_INDEX = 60
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        rx_valid,
    input  logic        rx_ide,
    input  logic        rx_rtr,
    input  logic [28:0] rx_id,
    input  logic [3:0]  rx_dlc,
    input  logic [63:0] rx_data,
    input  logic [15:0] rx_stamp,
    input  logic [2:0]  reg_addr,
    input  logic        reg_we,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata,
    input  logic [5:0]  mbx_sel,
    output logic [31:0] mbx_id,
    output logic [7:0]  mbx_dlc,
    output logic [63:0] mbx_data,
    output logic [15:0] mbx_stamp,
    output logic        rx_irq
);
    rx_frame_t in_frame, head_frame, last_frame;
    logic      en, discard_mode, pop_req, empty, stored, lost;

    assign in_frame = '{ide: rx_ide, rtr: rx_rtr, id: rx_id, dlc: rx_dlc,
                        data: rx_data, stamp: rx_stamp};

    rxf_regs u_regs (
        .clk          (clk),
        .rst          (rst),
        .reg_addr     (reg_addr),
        .reg_we       (reg_we),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .empty        (empty),
        .stored       (stored),
        .lost         (lost),
        .en           (en),
        .discard_mode (discard_mode),
        .pop_req      (pop_req),
        .rx_irq       (rx_irq)
    );

    rxf_store #(.DEPTH(DEPTH)) u_store (
        .clk          (clk),
        .rst          (rst),
        .en           (en),
        .discard_mode (discard_mode),
        .push         (rx_valid),
        .push_frame   (in_frame),
        .pop_req      (pop_req),
        .head_frame   (head_frame),
        .last_frame   (last_frame),
        .empty        (empty),
        .stored       (stored),
        .lost         (lost)
    );

    rxf_window #(.MBX_W(6), .WIN_INDEX(WIN_INDEX)) u_window (
        .mbx_sel    (mbx_sel),
        .empty      (empty),
        .head_frame (head_frame),
        .last_frame (last_frame),
        .mbx_id     (mbx_id),
        .mbx_dlc    (mbx_dlc),
        .mbx_data   (mbx_data),
        .mbx_stamp  (mbx_stamp)
    );

endmodule

// File: tb/can_rxfifo_window_bench.sv
`timescale 1ns/1ps
module can_rxfifo_window_bench;
    import can_rxf_pkg::*;

    logic        clk = 1'b0;
    logic        rst;
    logic        rx_valid, rx_ide, rx_rtr;
    logic [28:0] rx_id;
    logic [3:0]  rx_dlc;
    logic [63:0] rx_data;
    logic [15:0] rx_stamp;
    logic [2:0]  reg_addr;
    logic        reg_we;
    logic [7:0]  reg_wdata, reg_rdata;
    logic [5:0]  mbx_sel;
    logic [31:0] mbx_id;
    logic [7:0]  mbx_dlc;
    logic [63:0] mbx_data;
    logic [15:0] mbx_stamp;
    logic        rx_irq;

    always #2 clk = ~clk;

    can_rxfifo_window u_can_rxfifo_window (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_ide(rx_ide), .rx_rtr(rx_rtr),
        .rx_id(rx_id), .rx_dlc(rx_dlc), .rx_data(rx_data), .rx_stamp(rx_stamp),
        .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mbx_sel(mbx_sel), .mbx_id(mbx_id), .mbx_dlc(mbx_dlc), .mbx_data(mbx_data),
        .mbx_stamp(mbx_stamp), .rx_irq(rx_irq)
    );

    int        n_chk = 0;
    int        n_fail = 0;
    rx_frame_t exp_q[$];
    rx_frame_t last_out;
    logic      m_en = 1'b0;
    logic      m_discard = 1'b0;
    logic [7:0] rd;

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic rx_frame_t mk(input int k);
        rx_frame_t f;
        f.ide   = k[0];
        f.rtr   = (k % 3) == 0;
        f.id    = f.ide ? 29'(k * 32'h0135_79BD + 32'h0ABC) : {18'b0, 11'(k * 91 + 3)};
        f.dlc   = 4'(k % 9);
        f.data  = 64'(k) * 64'h0101_0101_0101_0101 ^ 64'h0F1E_2D3C_4B5A_6978;
        f.stamp = 16'(k * 613);
        return f;
    endfunction

    function automatic logic [31:0] exp_id(input rx_frame_t f);
        if (f.ide) return {1'b1, f.rtr, f.id};
        return {1'b0, f.rtr, f.id[10:0], 18'b0};
    endfunction

    // one combined cycle: optional frame and optional register write
    task automatic cycle(input bit do_rx, input rx_frame_t f, input bit do_wr,
                         input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        rx_valid = do_rx; rx_ide = f.ide; rx_rtr = f.rtr; rx_id = f.id;
        rx_dlc = f.dlc; rx_data = f.data; rx_stamp = f.stamp;
        reg_we = do_wr; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        rx_valid = 1'b0; reg_we = 1'b0;
    endtask

    // driver: models the queue and pushes expected items
    task automatic send(input rx_frame_t f);
        if (m_en) begin
            if (exp_q.size() < 4) exp_q.push_back(f);
            else if (!m_discard) exp_q[exp_q.size()-1] = f;
        end
        cycle(1'b1, f, 1'b0, 3'd0, 8'h00);
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [7:0] d);
        if (a == 3'd0) begin
            m_en = d[0]; m_discard = d[3];
            if (!d[0]) exp_q.delete();
        end
        cycle(1'b0, '0, 1'b1, a, d);
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic cmp_window(input string req, input rx_frame_t e);
        mbx_sel = 6'd60;
        #1;
        chk(req, "id", {32'b0, mbx_id}, {32'b0, exp_id(e)});
        chk(req, "dlc", {56'b0, mbx_dlc}, {60'b0, e.dlc});
        chk(req, "data", mbx_data, e.data);
        chk(req, "stamp", {48'b0, mbx_stamp}, {48'b0, e.stamp});
    endtask

    // monitor: compare head against scoreboard front, then advance
    task automatic pop_check(input string req);
        rx_frame_t e;
        if (exp_q.size() == 0) begin
            chk(req, "scoreboard nonempty", 64'd0, 64'd1);
            return;
        end
        e = exp_q.pop_front();
        cmp_window(req, e);
        last_out = e;
        cycle(1'b0, '0, 1'b1, 3'd1, 8'hFF);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst = 1'b1; rx_valid = 1'b0; rx_ide = 1'b0; rx_rtr = 1'b0; rx_id = '0;
        rx_dlc = '0; rx_data = '0; rx_stamp = '0; reg_addr = '0; reg_we = 1'b0;
        reg_wdata = '0; mbx_sel = 6'd60; last_out = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        reg_read(3'd0, rd); chk("R1", "cfg", {56'b0, rd}, 64'h80);
        reg_read(3'd2, rd); chk("R1", "irq stat", {56'b0, rd}, 64'h00);
        reg_read(3'd4, rd); chk("R1", "err", {56'b0, rd}, 64'h00);
        chk("R1", "irq", {63'b0, rx_irq}, 64'd0);
        cmp_window("R1", '0);

        // R2 frames ignored while disabled
        send(mk(1));
        reg_read(3'd0, rd); chk("R2", "cfg while off", {56'b0, rd}, 64'h80);

        // enable, discard mode
        reg_write(3'd0, 8'h09);
        reg_read(3'd0, rd); chk("R10", "cfg empty on", {56'b0, rd}, 64'h89);
        send(mk(2)); send(mk(3));
        reg_read(3'd0, rd); chk("R10", "cfg not empty", {56'b0, rd}, 64'h09);
        reg_read(3'd2, rd); chk("R8", "isr set", {56'b0, rd}, 64'h10);
        chk("R8", "irq gated off", {63'b0, rx_irq}, 64'd0);
        reg_write(3'd3, 8'h10);
        chk("R8", "irq enabled", {63'b0, rx_irq}, 64'd1);
        reg_write(3'd2, 8'h10);
        chk("R8", "write one keeps", {63'b0, rx_irq}, 64'd1);
        reg_write(3'd2, 8'hEF);
        reg_read(3'd2, rd); chk("R8", "isr cleared", {56'b0, rd}, 64'h00);
        chk("R8", "irq cleared", {63'b0, rx_irq}, 64'd0);

        // R9 other mailbox reads zero
        mbx_sel = 6'd59; #1;
        chk("R9", "id mbx59", {32'b0, mbx_id}, 64'd0);
        chk("R9", "data mbx59", mbx_data, 64'd0);
        mbx_sel = 6'd60;

        // R4 non-advance value ignored
        reg_write(3'd1, 8'h7F);
        cmp_window("R4", exp_q[0]);
        pop_check("R3");
        pop_check("R3");

        // R5 empty behaviour
        reg_read(3'd0, rd); chk("R10", "empty after drain", {56'b0, rd}, 64'h89);
        cmp_window("R5", last_out);
        cycle(1'b0, '0, 1'b1, 3'd1, 8'hFF);
        cmp_window("R5", last_out);
        send(mk(4));
        pop_check("R5");

        // R6 discard on full
        for (int k = 5; k <= 10; k++) send(mk(k));
        reg_read(3'd4, rd); chk("R6", "overrun flag", {56'b0, rd}, 64'h20);
        for (int k = 0; k < 4; k++) pop_check("R6");
        reg_read(3'd0, rd); chk("R6", "empty after 4", {56'b0, rd}, 64'h89);
        reg_write(3'd4, 8'h00);
        reg_read(3'd4, rd); chk("R6", "overrun cleared", {56'b0, rd}, 64'h00);

        // R7 replace on full
        reg_write(3'd0, 8'h01);
        for (int k = 11; k <= 15; k++) send(mk(k));
        reg_read(3'd4, rd); chk("R7", "overrun flag", {56'b0, rd}, 64'h20);
        for (int k = 0; k < 4; k++) pop_check("R7");
        reg_read(3'd0, rd); chk("R7", "empty after 4", {56'b0, rd}, 64'h81);
        reg_write(3'd4, 8'h00);

        // R11 push and advance together on full queue
        for (int k = 16; k <= 19; k++) send(mk(k));
        cmp_window("R11", exp_q[0]);
        void'(exp_q.pop_front());
        exp_q.push_back(mk(20));
        cycle(1'b1, mk(20), 1'b1, 3'd1, 8'hFF);
        reg_read(3'd4, rd); chk("R11", "no overrun", {56'b0, rd}, 64'h00);
        for (int k = 0; k < 4; k++) pop_check("R11");

        // R8 store wins over clear in same cycle
        reg_write(3'd2, 8'h00);
        reg_read(3'd2, rd); chk("R8", "isr clear before race", {56'b0, rd}, 64'h00);
        exp_q.push_back(mk(21));
        cycle(1'b1, mk(21), 1'b1, 3'd2, 8'h00);
        reg_read(3'd2, rd); chk("R8", "set wins", {56'b0, rd}, 64'h10);

        // R2 disable flushes the queue
        send(mk(22));
        reg_write(3'd0, 8'h00);
        reg_read(3'd0, rd); chk("R2", "cfg off", {56'b0, rd}, 64'h80);
        reg_write(3'd0, 8'h01);
        reg_read(3'd0, rd); chk("R2", "empty after re-enable", {56'b0, rd}, 64'h81);
        send(mk(23));
        pop_check("R2");

        finish_run();
    end

endmodule